// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse-Width Modulator

This peripheral drives two independent pulse-width-modulated outputs from a single clock. Each channel has one 32-bit control word, accessed through a word-addressed register port with a same-cycle read path. The control word holds three fields: a run bit, an 8-bit step divider and an 8-bit duty code.

A running channel divides the clock by its divider to make step ticks. Every 256 steps form one output period. The output is high at the start of each period and drops once the step count reaches 256 minus the duty code. A duty code of zero keeps the line low for the whole period. A divider of zero stands for 256.

Divider and duty values are copied into a per-channel working copy only at a period boundary, or while the channel is stopped. A write in the middle of a period therefore never cuts a pulse short.

Top module: `dual_step_pwm`

## Requirements
- R1: Channel c has a 32-bit register at byte address 4*c. Bit 31 is the run bit, bits 15:8 the divider and bits 7:0 the duty code. A write stores all 32 bits, and a read returns the addressed register in the same cycle.
- R2: After reset, every register reads zero and every output is low.
- R3: One clock after a write that clears the run bit, the output is low and stays low. After a write that sets it, the output is high from the second clock edge after the write edge, at the start of a fresh period.
- R4: Each step lasts N clocks for a divider value N from 1 to 255, and 256 clocks for a divider value of 0.
- R5: With a duty code D from 1 to 255 and a step length of S clocks, each period is high for (256-D)*S clocks and then low for D*S clocks.
- R6: With a duty code of 0, the output stays low while the channel runs.
- R7: Bits 30:16 read back as written and have no effect on the output.
- R8: A divider or duty write made during a period leaves that period unchanged and applies from the next period on.
- R9: The channels run independently: writing one channel changes neither the register nor the output timing of the other.
- R10: An output rises only at the first step of a period.
- R11: Writes to an address that is not word-aligned or lies beyond the last channel are ignored, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address of the register |
| wr_en_i | input | 1 | Write strobe, one write per clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pwm_o | output | 2 | One modulated output per channel |

## Verification
- **Register path:** register contents are due on the clock edge that takes the write, and read data follows the address in the same cycle. The bench drives every input on falling edges and reads back one falling edge later.
- **Starting and stopping:** a stop is visible one edge after the write, and a start shows as a rising output two edges after the write.
- **Pulse widths:** the bench counts high and low samples, one per falling edge, from a rising output to the next rising output. These counts equal the required clock counts whatever the start-up latency.
- **Mid-period changes:** the bench changes the configuration a few clocks into a high phase. It then expects the old width for the rest of that period and the new width in the following one.

// File: rtl/dual_step_pwm_pkg.sv
package dual_step_pwm_pkg;

  localparam int STEP_W   = 8;
  localparam int RSVD_W   = 32 - 1 - 2 * STEP_W;
  localparam int STEPS    = 1 << STEP_W;

  // Field order is fixed by software: run bit on top, duty code at the bottom
  typedef struct packed {
    logic              run;
    logic [RSVD_W-1:0] rsvd;
    logic [STEP_W-1:0] divider;
    logic [STEP_W-1:0] duty;
  } pwm_cfg_t;

endpackage

// File: rtl/pwm_cfg_regs.sv
module pwm_cfg_regs
  import dual_step_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_en_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output pwm_cfg_t [NUM_CH-1:0] cfg_o
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [ADDR_W-3:0] word;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  pwm_cfg_t [NUM_CH-1:0] cfg_q;

  assign word = addr_i[ADDR_W-1:2];
  assign idx  = word[IDX_W-1:0];
  assign hit  = (addr_i[1:0] == 2'b00) && (32'(word) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[c] <= '0;
      else if (wr_en_i && hit && (idx == IDX_W'(c)))
        cfg_q[c] <= pwm_cfg_t'(wdata_i);
    end

    p_write_store_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && hit && (idx == IDX_W'(c))) |=> (cfg_q[c] == $past(wdata_i)));
  end

  assign rdata_o = hit ? 32'(cfg_q[idx]) : '0;
  assign cfg_o   = cfg_q;

  p_bad_addr_ignored_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit) |=> $stable(cfg_q));

  p_bad_addr_reads_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> (rdata_o == 32'd0));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import dual_step_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic [STEP_W-1:0] divider_i,
  output logic              tick_o
);

  logic [STEP_W-1:0] cnt_q;
  logic              last;

  // divider 0 wraps the full counter range, i.e. 256 clocks per step
  assign last   = (cnt_q == divider_i - STEP_W'(1));
  assign tick_o = active_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (!active_i || last)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + STEP_W'(1);
  end

  p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divider_i != '0) |-> (cnt_q < divider_i));

  p_idle_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));

endmodule

// File: rtl/pwm_wave_gen.sv
module pwm_wave_gen
  import dual_step_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] duty_i,
  output logic              wrap_o,
  output logic              pwm_o
);

  logic [STEP_W-1:0] step_q;
  logic [STEP_W:0]   high_steps;
  logic              high_now;
  logic              out_q;

  assign wrap_o     = tick_i && (step_q == {STEP_W{1'b1}});
  assign high_steps = (STEP_W+1)'(STEPS) - {1'b0, duty_i};
  assign high_now   = (duty_i != '0) && ({1'b0, step_q} < high_steps);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      out_q  <= 1'b0;
    end else begin
      if (!active_i)
        step_q <= '0;
      else if (tick_i)
        step_q <= step_q + STEP_W'(1);
      out_q <= active_i && high_now;
    end
  end

  assign pwm_o = out_q;

  p_step_moves_on_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i) |=> $stable(step_q));

  p_zero_duty_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == '0) |=> !out_q);

  p_rise_at_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> ($past(step_q) == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import dual_step_pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [STEP_W-1:0] divider_i,
  input  logic [STEP_W-1:0] duty_i,
  output logic              pwm_o
);

  logic              run_q;
  logic              active;
  logic              tick;
  logic              wrap;
  logic [STEP_W-1:0] div_sh_q;
  logic [STEP_W-1:0] duty_sh_q;

  // one idle cycle after start lets the working copy pick up the new fields
  assign active = run_i && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      div_sh_q  <= '0;
      duty_sh_q <= '0;
    end else begin
      run_q <= run_i;
      if (!run_q || wrap) begin
        div_sh_q  <= divider_i;
        duty_sh_q <= duty_i;
      end
    end
  end

  pwm_prescaler u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (active),
    .divider_i (div_sh_q),
    .tick_o    (tick)
  );

  pwm_wave_gen u_wave (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (tick),
    .duty_i   (duty_sh_q),
    .wrap_o   (wrap),
    .pwm_o    (pwm_o)
  );

  p_hold_mid_period_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !wrap) |=> ($stable(div_sh_q) && $stable(duty_sh_q)));

  p_stop_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !pwm_o);

endmodule

// File: rtl/dual_step_pwm.sv
module dual_step_pwm
  import dual_step_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);

  pwm_cfg_t [NUM_CH-1:0] cfg;

  pwm_cfg_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (cfg[c].run),
      .divider_i (cfg[c].divider),
      .duty_i    (cfg[c].duty),
      .pwm_o     (pwm_o[c])
    );
  end

endmodule

// File: tb/dual_step_pwm_tb_top.sv
module dual_step_pwm_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm;

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  dual_step_pwm dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .addr_i  (addr),
    .wr_en_i (wr_en),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  function automatic logic [31:0] cfg(bit run, int div, int duty);
    return {run, 15'd0, 8'(div), 8'(duty)};
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = 8'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 8'(a);
    #1 d = rdata;
  endtask

  task automatic stop_all();
    wr(0, 32'd0); wr(4, 32'd0);
    repeat (3) @(negedge clk);
  endtask

  // rising output to next rising output, one sample per falling edge
  task automatic measure(int ch, output int hi, output int lo);
    hi = 0; lo = 0;
    while (pwm[ch]) @(negedge clk);
    while (!pwm[ch]) @(negedge clk);
    while (pwm[ch]) begin hi++; @(negedge clk); end
    while (!pwm[ch]) begin lo++; @(negedge clk); end
  endtask

  task automatic run_and_measure(string req, int ch, int div, int duty, int step);
    int hi, lo;
    stop_all();
    wr(ch * 4, cfg(1, div, duty));
    measure(ch, hi, lo);
    chk(req, $sformatf("ch%0d div=%0d duty=%0d high", ch, div, duty), hi, (256 - duty) * step);
    chk(req, $sformatf("ch%0d div=%0d duty=%0d low", ch, div, duty), lo, duty * step);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(0, d); chk("R2", "reg0 after reset", d, 0);
    rd(4, d); chk("R2", "reg1 after reset", d, 0);
    chk("R2", "outputs after reset", pwm, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(0, 32'h0000_3C21);
    wr(4, 32'h0000_0A99);
    rd(0, d); chk("R1", "reg0 readback", d, 32'h0000_3C21);
    rd(4, d); chk("R1", "reg1 readback", d, 32'h0000_0A99);
    stop_all();
  endtask

  task automatic t_restart();
    stop_all();
    wr(0, cfg(1, 1, 128));
    chk("R3", "output after write edge", pwm[0], 0);
    @(negedge clk);
    chk("R3", "output one edge after write", pwm[0], 0);
    @(negedge clk);
    chk("R3 R10", "output two edges after write (period start)", pwm[0], 1);
  endtask

  task automatic t_duty_sweep();
    run_and_measure("R5", 0, 1, 128, 1);
    run_and_measure("R5", 0, 1, 1, 1);
    run_and_measure("R5", 0, 1, 255, 1);
    run_and_measure("R4 R5", 1, 3, 200, 3);
  endtask

  task automatic t_zero_duty();
    int highs = 0;
    stop_all();
    wr(0, cfg(1, 1, 0));
    for (int i = 0; i < 600; i++) begin
      if (pwm[0]) highs++;
      @(negedge clk);
    end
    chk("R6", "high samples with duty 0", highs, 0);
  endtask

  task automatic t_slow_divider();
    run_and_measure("R4", 0, 0, 128, 256);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    int hi, lo;
    stop_all();
    wr(0, 32'hFABC_0180);
    rd(0, d); chk("R7", "reserved bits readback", d, 32'hFABC_0180);
    measure(0, hi, lo);
    chk("R7", "high with reserved bits set", hi, 128);
    chk("R7", "low with reserved bits set", lo, 128);
  endtask

  task automatic t_midway();
    int hi = 0, lo = 0, hi2 = 0, lo2 = 0;
    stop_all();
    wr(0, cfg(1, 2, 128));
    while (!pwm[0]) @(negedge clk);
    while (pwm[0]) begin
      if (hi == 5) begin addr = 8'd0; wdata = cfg(1, 2, 64); wr_en = 1'b1; end
      else wr_en = 1'b0;
      hi++;
      @(negedge clk);
    end
    wr_en = 1'b0;
    while (!pwm[0]) begin lo++; @(negedge clk); end
    while (pwm[0]) begin hi2++; @(negedge clk); end
    while (!pwm[0]) begin lo2++; @(negedge clk); end
    chk("R8", "high of period during write", hi, 256);
    chk("R8", "low of period during write", lo, 256);
    chk("R8", "high of next period", hi2, 384);
    chk("R8", "low of next period", lo2, 128);
  endtask

  task automatic t_independent();
    logic [31:0] d;
    int hi, lo;
    stop_all();
    wr(0, cfg(1, 1, 64));
    wr(4, cfg(1, 3, 192));
    measure(1, hi, lo);
    chk("R9", "ch1 high beside ch0", hi, 192);
    chk("R9", "ch1 low beside ch0", lo, 576);
    measure(0, hi, lo);
    chk("R9", "ch0 high beside ch1", hi, 192);
    chk("R9", "ch0 low beside ch1", lo, 64);
    rd(0, d); chk("R9", "ch0 register untouched", d, cfg(1, 1, 64));
  endtask

  task automatic t_disable();
    int highs = 0;
    stop_all();
    wr(0, cfg(1, 1, 1));
    while (!pwm[0]) @(negedge clk);
    repeat (10) @(negedge clk);
    wr(0, cfg(0, 1, 1));
    @(negedge clk);
    chk("R3", "output one edge after stop", pwm[0], 0);
    for (int i = 0; i < 400; i++) begin
      if (pwm[0]) highs++;
      @(negedge clk);
    end
    chk("R3", "high samples while stopped", highs, 0);
  endtask

  task automatic t_bad_addr();
    logic [31:0] d;
    stop_all();
    wr(0, 32'h0000_1111);
    wr(4, 32'h0000_2222);
    wr(8, 32'hFFFF_FFFF);
    wr(2, 32'hFFFF_FFFF);
    rd(0, d); chk("R11", "reg0 after stray writes", d, 32'h0000_1111);
    rd(4, d); chk("R11", "reg1 after stray writes", d, 32'h0000_2222);
    rd(8, d); chk("R11", "read beyond last channel", d, 0);
    chk("R11", "outputs after stray writes", pwm, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_restart();
    t_duty_sweep();
    t_zero_duty();
    t_slow_divider();
    t_reserved();
    t_midway();
    t_independent();
    t_disable();
    t_bad_addr();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (160000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_err++;
      $display("FAIL R5 watchdog: got timeout expected completion");
      report();
    end
  end

endmodule